// File: doc/BRIEF.md
# Nibble Stream Delimiter Substitution Pipeline

This block sits in a 4-bit streaming path. It watches the most recent input words through a short delay line and looks for frame delimiters. When it finds a start delimiter, it loads a preamble image into four 24-deep bit lanes so the preamble leaves just ahead of the delimiter. When it finds a closing run of all-ones words, it overwrites that run with zeros. Every input word that has not been replaced keeps a fixed distance to the output. Substitution does not cost a cycle, and it never drops a newly arriving word.

A word moves through the block only on a *step*. A step is a cycle in which `din_vld` is high and the registered copy of `en_in` is high. `en_in` comes from an unrelated timing domain, so the block registers it once before it reaches any other flop. The block then alternates between two phases. In the first it hunts for a start delimiter. In the second it hunts for the closing run.

Top module: `nib_subst_pipe`

## Requirements
- R1: A synchronous active-high `rst` clears the delay line, the lanes, the counters and the flags. After the next clock edge `dout` is 0000, and `dout_vld` and `match` are 0.
- R2: `en_in` takes effect one clock later. It gates the cycle after the one in which it was sampled. In a cycle that is not a step, `dout`, `dout_vld` and `match` hold their values, and an input word present in that cycle has no effect.
- R3: When no substitution applies, a word accepted on step j appears on `dout` right after step j+26 (TAPS + DEPTH − 1). Before that, `dout` shows 0000.
- R4: While hunting for a start, a step whose input word equals 1011 is a start hit. `match` goes high at the end of that step and stays high until the end of the next step.
- R5: On the step after a start hit k, the lanes load the preamble image in the same cycle that they accept the serial word. `dout` then shows image nibbles 22 down to 0 after steps k+1 to k+23. Nibble p of the image is bits [4p+3:4p] of `PRE_IMG`. The word accepted on step k−2 and every later word keep the R3 delay, so the 1011 word leaves after the preamble.
- R6: `dout_vld` rises at the end of the step on which the preamble loads.
- R7: While hunting for the closing run, a 1011 word causes no hit and no load.
- R8: While hunting for the closing run, the word leaving the delay line is counted when it is 1111. When the 24th consecutive 1111 word arrives at step h, the step is an end hit. That is TAPS steps after the last of the 1111 words was accepted. On step h+1 the lanes load zeros. `dout` keeps the first 1111 word of the run, then shows 0000 after steps h+1 to h+23, then resumes the R3 stream. The hunt returns to the start phase from step h+1.
- R9: Any word other than 1111 that leaves the delay line clears the run count, so only an unbroken run of 24 ends a frame.
- R10: After an end hit at step h, `dout_vld` falls at the end of step h+24, when the first word after the zeroed run appears. A preamble load before that point keeps `dout_vld` high.
- R11: A start hit is accepted as soon as the start phase resumes. A later load replaces the lane contents left by an earlier one.
- R12: If the cycle after a hit is not a step, the load waits for the next step and `match` stays high, so no input word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_in | input | 1 | Enable from an unrelated source, registered before use |
| din | input | 4 | Input word |
| din_vld | input | 1 | Input word is present |
| dout | output | 4 | Output word, taken from the lane tails |
| dout_vld | output | 1 | A frame is being presented on `dout` |
| match | output | 1 | A delimiter hit is waiting for its load step |

## Verification
The assertions check on every cycle that nothing moves in a non-step cycle and that a pending hit persists until a step. They also check that the first output after a load is image nibble 22 or a zero, and that `dout_vld` changes only on a preamble load or at the end of the drain count. Only the bench scenarios can show the exact positions of the preamble and the zeroed run within the stream, and that the 1011 word and the words around it survive the merged load. The same holds for a broken 1111 run being ignored, a 1011 word inside a frame being ignored, and a preamble load overriding a drain that is still in progress.

// File: rtl/nsp_pkg.sv
package nsp_pkg;

  typedef enum logic {
    HUNT_OPEN  = 1'b0,
    HUNT_CLOSE = 1'b1
  } hunt_e;

  typedef enum logic {
    IMG_PREAMBLE = 1'b0,
    IMG_BLANK    = 1'b1
  } img_e;

  function automatic int unsigned cnt_w(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/nsp_en_reg.sv
module nsp_en_reg (
  input  logic clk,
  input  logic rst,
  input  logic en_in,
  output logic en_q
);

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= en_in;
  end

endmodule

// File: rtl/nsp_window.sv
module nsp_window #(
  parameter int unsigned W    = 4,
  parameter int unsigned TAPS = 3,
  parameter logic [(TAPS+1)*W-1:0] PAT  = '0,
  parameter logic [(TAPS+1)*W-1:0] MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] din,
  output logic [W-1:0] tail,
  output logic         hit
);

  localparam int unsigned WIN_W = (TAPS + 1) * W;

  logic [W-1:0]     dly [TAPS];
  logic [WIN_W-1:0] win;

  function automatic logic masked_eq(input logic [WIN_W-1:0] a,
                                     input logic [WIN_W-1:0] b,
                                     input logic [WIN_W-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) dly[i] <= '0;
    end else if (step) begin
      dly[0] <= din;
      for (int i = 1; i < TAPS; i++) dly[i] <= dly[i-1];
    end
  end

  assign win[TAPS*W +: W] = din;
  generate
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign win[(TAPS-1-t)*W +: W] = dly[t];
    end
  endgenerate

  assign tail = dly[TAPS-1];
  assign hit  = masked_eq(win, PAT, MASK);

endmodule

// File: rtl/nsp_run.sv
module nsp_run
  import nsp_pkg::*;
#(
  parameter int unsigned W   = 4,
  parameter int unsigned RUN = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         armed,
  input  logic [W-1:0] word,
  output logic         done
);

  localparam int unsigned CW = cnt_w(RUN);

  logic [CW-1:0] cnt;
  logic          ones;

  assign ones = &word;
  assign done = step & armed & ones & (cnt == CW'(RUN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (step) begin
      if (!armed || !ones || done) cnt <= '0;
      else                         cnt <= cnt + CW'(1);
    end
  end

  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(RUN));

endmodule

// File: rtl/nsp_lane.sv
module nsp_lane #(
  parameter int unsigned DEPTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             load,
  input  logic [DEPTH-2:0] img,
  input  logic             sin,
  output logic             sout
);

  logic [DEPTH-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (step) q <= load ? {img, sin} : {q[DEPTH-2:0], sin};
  end

  assign sout = q[DEPTH-1];

endmodule

// File: rtl/nib_subst_pipe.sv
module nib_subst_pipe
  import nsp_pkg::*;
#(
  parameter int unsigned W     = 4,
  parameter int unsigned DEPTH = 24,
  parameter int unsigned TAPS  = 3,
  parameter int unsigned RUN   = 24,
  parameter logic [(TAPS+1)*W-1:0] START_PAT  = {W'(11), {(TAPS*W){1'b0}}},
  parameter logic [(TAPS+1)*W-1:0] START_MASK = {{W{1'b1}}, {(TAPS*W){1'b0}}},
  parameter logic [W*DEPTH-1:0]    PRE_IMG    = {DEPTH{W'(5)}}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_in,
  input  logic [W-1:0] din,
  input  logic         din_vld,
  output logic [W-1:0] dout,
  output logic         dout_vld,
  output logic         match
);

  localparam int unsigned DRAIN_W = cnt_w(DEPTH);

  typedef struct packed {
    logic               live;
    logic [DRAIN_W-1:0] left;
  } out_t;

  logic         en_q;
  logic         step;
  logic [W-1:0] tail;
  logic         win_hit;
  logic         start_go;
  logic         end_go;
  logic         pend;
  hunt_e        hunt;
  img_e         kind;
  out_t         ost;
  logic [W-1:0] lane_out;

  function automatic logic [DEPTH-2:0] lane_image(input int unsigned b);
    logic [DEPTH-2:0] r;
    for (int p = 0; p < DEPTH - 1; p++) r[p] = PRE_IMG[p*W + b];
    return r;
  endfunction

  function automatic out_t next_out(input out_t cur, input logic pre_ld,
                                    input logic blank_ld);
    out_t n;
    n = cur;
    if (pre_ld) begin
      n.live = 1'b1;
      n.left = '0;
    end else if (blank_ld) begin
      n.left = DRAIN_W'(DEPTH - 1);
    end else if (cur.left != '0) begin
      n.left = cur.left - DRAIN_W'(1);
      if (cur.left == DRAIN_W'(1)) n.live = 1'b0;
    end
    return n;
  endfunction

  nsp_en_reg u_en (
    .clk   (clk),
    .rst   (rst),
    .en_in (en_in),
    .en_q  (en_q)
  );

  assign step = en_q & din_vld;

  nsp_window #(
    .W    (W),
    .TAPS (TAPS),
    .PAT  (START_PAT),
    .MASK (START_MASK)
  ) u_win (
    .clk  (clk),
    .rst  (rst),
    .step (step),
    .din  (din),
    .tail (tail),
    .hit  (win_hit)
  );

  nsp_run #(
    .W   (W),
    .RUN (RUN)
  ) u_run (
    .clk   (clk),
    .rst   (rst),
    .step  (step),
    .armed (hunt == HUNT_CLOSE),
    .word  (tail),
    .done  (end_go)
  );

  assign start_go = step & (hunt == HUNT_OPEN) & win_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      hunt <= HUNT_OPEN;
      pend <= 1'b0;
      kind <= IMG_PREAMBLE;
      ost  <= '0;
    end else if (step) begin
      pend <= start_go | end_go;
      if (start_go) begin
        kind <= IMG_PREAMBLE;
        hunt <= HUNT_CLOSE;
      end else if (end_go) begin
        kind <= IMG_BLANK;
        hunt <= HUNT_OPEN;
      end
      ost <= next_out(ost, pend && (kind == IMG_PREAMBLE),
                           pend && (kind == IMG_BLANK));
    end
  end

  generate
    for (genvar g = 0; g < W; g++) begin : g_lane
      localparam logic [DEPTH-2:0] IMG_L = lane_image(g);
      logic [DEPTH-2:0] ld_img;
      assign ld_img = (kind == IMG_PREAMBLE) ? IMG_L : '0;
      nsp_lane #(.DEPTH(DEPTH)) u_lane (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .load (pend),
        .img  (ld_img),
        .sin  (tail[g]),
        .sout (lane_out[g])
      );
    end
  endgenerate

  assign dout     = lane_out;
  assign dout_vld = ost.live;
  assign match    = pend;

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(en_in, 2) && $past(din_vld)))
      |-> ($stable(dout) && $stable(dout_vld) && $stable(match)));

  a_r5_image_first: assert property (@(posedge clk) disable iff (rst)
    (step && pend && kind == IMG_PREAMBLE)
      |=> (dout == PRE_IMG[(DEPTH-2)*W +: W]));

  a_r8_blank_first: assert property (@(posedge clk) disable iff (rst)
    (step && pend && kind == IMG_BLANK) |=> (dout == '0));

  a_r6_vld_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_vld) |-> $past(step && pend && kind == IMG_PREAMBLE));

  a_r10_vld_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(dout_vld) |-> $past(step && ost.left == DRAIN_W'(1)));

  a_r12_match_waits: assert property (@(posedge clk) disable iff (rst)
    (match && !step) |=> match);

  a_r4_match_from_step: assert property (@(posedge clk) disable iff (rst)
    $rose(match) |-> $past(step));

endmodule

// File: tb/test_nib_subst_pipe.sv
module test_nib_subst_pipe;

  localparam int N = 400;
  localparam int DLY = 26;

  function automatic logic [95:0] bench_img();
    logic [95:0] r;
    for (int p = 0; p < 24; p++) r[p*4 +: 4] = 4'((p * 7 + 3) % 16);
    return r;
  endfunction

  function automatic logic [3:0] img_nib(input int p);
    return 4'((p * 7 + 3) % 16);
  endfunction

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_in = 1'b0;
  logic [3:0] din = '0;
  logic       din_vld = 1'b0;
  logic [3:0] dout;
  logic       dout_vld;
  logic       match;

  int n_chk = 0;
  int n_err = 0;

  logic [3:0] w  [N];
  logic [3:0] ed [N];
  logic       ev [N];
  logic       em [N];
  string      tg [N];
  logic       s_hit [N];
  logic       e_hit [N];

  always #2 clk = ~clk;

  nib_subst_pipe #(.PRE_IMG(bench_img())) i_nib_subst_pipe (
    .clk      (clk),
    .rst      (rst),
    .en_in    (en_in),
    .din      (din),
    .din_vld  (din_vld),
    .dout     (dout),
    .dout_vld (dout_vld),
    .match    (match)
  );

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] pd(input int s);
    return (s < 0) ? 4'h0 : ed[s];
  endfunction
  function automatic logic pv(input int s);
    return (s < 0) ? 1'b0 : ev[s];
  endfunction
  function automatic logic pm(input int s);
    return (s < 0) ? 1'b0 : em[s];
  endfunction

  task automatic step_cycle(input int s, input logic en);
    en_in = en; din = w[s]; din_vld = 1'b1;
    @(posedge clk); @(negedge clk);
    check(tg[s], "dout", 8'(dout), 8'(ed[s]));
    check(ev[s] ? "R6" : "R10", "dout_vld", 8'(dout_vld), 8'(ev[s]));
    check("R4", "match", 8'(match), 8'(em[s]));
  endtask

  task automatic hold_cycle(input int prev, input logic vld_in, input logic en);
    string t;
    t = pm(prev) ? "R12" : "R2";
    en_in = en; din = 4'hB; din_vld = vld_in;
    @(posedge clk); @(negedge clk);
    check(t, "dout hold", 8'(dout), 8'(pd(prev)));
    check(t, "dout_vld hold", 8'(dout_vld), 8'(pv(prev)));
    check(t, "match hold", 8'(match), 8'(pm(prev)));
  endtask

  task automatic build_model();
    int hunt, cnt, live, left;
    logic [3:0] lin;
    for (int j = 0; j < N; j++) begin
      w[j] = 4'((j * 5 + 1) % 16);
      if (w[j] == 4'hB || w[j] == 4'hF) w[j] = 4'h3;
    end
    for (int j = 5; j <= 34; j++) w[j] = 4'hF;
    w[40] = 4'hB;
    w[60] = 4'hB;
    for (int j = 80; j <= 102; j++) w[j] = 4'hF;
    w[103] = 4'h2;
    for (int j = 104; j <= 127; j++) w[j] = 4'hF;
    w[200] = 4'hB;
    for (int j = 230; j <= 253; j++) w[j] = 4'hF;
    w[258] = 4'hB;
    for (int j = 300; j <= 323; j++) w[j] = 4'hF;

    hunt = 0; cnt = 0;
    for (int j = 0; j < N; j++) begin
      s_hit[j] = 1'b0; e_hit[j] = 1'b0;
      lin = (j >= 3) ? w[j-3] : 4'h0;
      if (hunt == 0) begin
        cnt = 0;
        if (w[j] == 4'hB) begin s_hit[j] = 1'b1; hunt = 1; end
      end else if (lin == 4'hF) begin
        cnt++;
        if (cnt == 24) begin e_hit[j] = 1'b1; hunt = 0; cnt = 0; end
      end else begin
        cnt = 0;
      end
    end

    for (int s = 0; s < N; s++) begin
      ed[s] = (s >= DLY) ? w[s-DLY] : 4'h0;
      tg[s] = "R3";
    end
    for (int k = 0; k < N; k++) begin
      for (int m = 0; m < 23; m++) begin
        if (k + 1 + m < N && s_hit[k]) begin
          ed[k+1+m] = img_nib(22 - m); tg[k+1+m] = "R5";
        end
        if (k + 1 + m < N && e_hit[k]) begin
          ed[k+1+m] = 4'h0; tg[k+1+m] = "R8";
        end
      end
    end
    tg[60 + DLY] = "R7";
    for (int s = 131; s <= 153; s++) tg[s] = "R9";
    for (int s = 259; s <= 281; s++) tg[s] = "R11";

    live = 0; left = 0;
    for (int s = 0; s < N; s++) begin
      if (s > 0 && s_hit[s-1]) begin live = 1; left = 0; end
      else if (s > 0 && e_hit[s-1]) left = 23;
      else if (left > 0) begin
        if (left == 1) live = 0;
        left--;
      end
      ev[s] = live[0];
      em[s] = s_hit[s] | e_hit[s];
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    build_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "dout after reset", 8'(dout), 8'h0);
    check("R1", "dout_vld after reset", 8'(dout_vld), 8'h0);
    check("R1", "match after reset", 8'(match), 8'h0);
    rst = 1'b0;
    hold_cycle(-1, 1'b1, 1'b1);

    for (int s = 0; s < N; s++) begin
      if (s % 7 == 6 || s == 41 || s == 131 || s == 259)
        hold_cycle(s - 1, 1'b0, 1'b1);
      if (s == 150) begin
        step_cycle(s, 1'b0);
        for (int r = 0; r < 3; r++) hold_cycle(s, 1'b1, 1'b0);
        hold_cycle(s, 1'b1, 1'b1);
      end else begin
        step_cycle(s, 1'b1);
      end
    end

    rst = 1'b1; din_vld = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1", "dout after late reset", 8'(dout), 8'h0);
    check("R1", "dout_vld after late reset", 8'(dout_vld), 8'h0);
    check("R1", "match after late reset", 8'(match), 8'h0);
    rst = 1'b0;

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule